// File: doc/BRIEF.md
# System Control Register Bank

This block is a memory-mapped register bank through which software reads board status and asks for a system reset or a power-off. It is a slave on a simple 32-bit register bus with separate write and read channels. Each channel has a valid/ready handshake. The bus covers a 4 KiB byte window. Behind the window are 512 words of 32-bit storage that software can read and write. The word index is taken from byte-address bits [10:2]. The upper 2 KiB of the window therefore aliases the lower 2 KiB in storage.

Command and status behaviour is decoded on the full byte offset:
- A write to offset 0xF00 carrying a command code raises a single-cycle reset-request pulse or shutdown-request pulse. The block only issues these requests; it does not sequence the reset itself.
- Reads from three status offsets return the stored word with two status bits forced high.
- Four identification words take fixed values when the block's own reset is applied. All other words clear to zero.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset, word index 0x40 holds 0x05F20121, index 0x41 holds 0x00000002, index 0x42 holds 0x05F30121 and index 0x43 holds 0x05F40121. These are byte offsets 0x100, 0x104, 0x108 and 0x10C. A read at 0x104 returns 0x00000002 exactly.
- R2: After reset, every other word reads as zero.
- R3: A write stores its data in word index addr[10:2]. A later read of any address mapping to that index returns the data. Address bits [1:0] are ignored. Offsets 0x800 and above alias the word at the offset minus 0x800.
- R4: A write to byte offset 0xF00 with data 1 or 2 raises resetReq for exactly one cycle, in the cycle after the write is accepted.
- R5: A write to byte offset 0xF00 with data 3 raises shutdownReq for exactly one cycle, in the cycle after the write is accepted.
- R6: No request is raised by either of these writes:
  - a write to 0xF00 with any value other than 1, 2 or 3;
  - a write of 1, 2 or 3 to any other offset, including the alias 0x700.
- R7: A write to 0xF00 also stores its data, which reads back unchanged at 0xF00.
- R8: Reads at byte offsets 0x100, 0x108 and 0x10C return the stored word ORed with 0x30000000 (bits 29 and 28 set). A read at any other offset returns the stored word unmodified.
- R9: Read data and rdDataValid appear in the cycle after a read is accepted. rdDataValid is low in every other cycle.
- R10: Issuing a reset or shutdown request leaves all stored words unchanged. Only rstN restores the reset values.
- R11: wrReady and rdReady are always high, so every valid request is accepted in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Write request valid |
| wrReady | output | 1 | Write request accepted (always high) |
| wrAddr | input | 12 | Write byte offset |
| wrData | input | 32 | Write data |
| rdValid | input | 1 | Read request valid |
| rdReady | output | 1 | Read request accepted (always high) |
| rdAddr | input | 12 | Read byte offset |
| rdDataValid | output | 1 | Read data valid, one cycle after acceptance |
| rdData | output | 32 | Read data with status overlay applied |
| resetReq | output | 1 | Single-cycle system reset request |
| shutdownReq | output | 1 | Single-cycle shutdown request |

## Verification
The assertions assume the following about the inputs:
- While rstN is low, wrValid and rdValid stay low. This ensures that the past-cycle checks on request causes and read latency never see a request made during reset.
- Requests are full 32-bit accesses.

The stimulus meets these assumptions:
- Valid signals are held low throughout reset.
- Inputs are driven only on falling edges.
- A read and a write to the same word are never issued in the same cycle.
- Command writes are separated by idle cycles, so each request pulse can be seen falling back low.

// File: rtl/sysctl_regbank_pkg.sv
package sysctl_regbank_pkg;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 32;
  localparam int NUM_WORDS = 512;
  localparam int IDX_W    = $clog2(NUM_WORDS);
  localparam int OFF_W    = ADDR_W - 2;

  localparam logic [ADDR_W-1:0] CMD_OFFSET  = 12'hF00;
  localparam logic [DATA_W-1:0] STATUS_MASK = 32'h3000_0000;

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
    logic             rdEn;
    logic [IDX_W-1:0] rdIdx;
    logic             forceBits;
  } ctrlStrobes_t;

  function automatic logic [DATA_W-1:0] resetWord(input int idx);
    case (idx)
      'h40:    return 32'h05F2_0121;
      'h41:    return 32'h0000_0002;
      'h42:    return 32'h05F3_0121;
      'h43:    return 32'h05F4_0121;
      default: return '0;
    endcase
  endfunction

  function automatic logic isStatusOffset(input logic [ADDR_W-1:0] addr);
    return (addr[ADDR_W-1:2] == OFF_W'(12'h100 >> 2)) ||
           (addr[ADDR_W-1:2] == OFF_W'(12'h108 >> 2)) ||
           (addr[ADDR_W-1:2] == OFF_W'(12'h10C >> 2));
  endfunction
endpackage

// File: rtl/sysctl_regbank_ctrl.sv
module sysctl_regbank_ctrl
  import sysctl_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdValid,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              wrReady,
  output logic              rdReady,
  output ctrlStrobes_t      strobes,
  output logic              resetReq,
  output logic              shutdownReq
);
  localparam logic [OFF_W-1:0] CMD_WORD = CMD_OFFSET[ADDR_W-1:2];

  logic wrFire;
  logic rdFire;
  logic cmdHit;
  logic isResetCode;
  logic isShutdownCode;
  logic unusedAddrBits;

  assign wrReady = 1'b1;
  assign rdReady = 1'b1;
  assign wrFire  = wrValid && wrReady;
  assign rdFire  = rdValid && rdReady;

  assign unusedAddrBits = ^{wrAddr[1:0], rdAddr[1:0]};

  assign cmdHit         = wrFire && (wrAddr[ADDR_W-1:2] == CMD_WORD);
  assign isResetCode    = (wrData == DATA_W'(1)) || (wrData == DATA_W'(2));
  assign isShutdownCode = (wrData == DATA_W'(3));

  always_comb begin
    strobes.wrEn      = wrFire;
    strobes.wrIdx     = wrAddr[IDX_W+1:2];
    strobes.rdEn      = rdFire;
    strobes.rdIdx     = rdAddr[IDX_W+1:2];
    strobes.forceBits = isStatusOffset(rdAddr);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resetReq    <= 1'b0;
      shutdownReq <= 1'b0;
    end else begin
      resetReq    <= cmdHit && isResetCode;
      shutdownReq <= cmdHit && isShutdownCode;
    end
  end

  // R4: a reset pulse only follows an accepted command write of 1 or 2
  a_r4_reset_cause: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> $past(wrValid && wrAddr[ADDR_W-1:2] == CMD_WORD &&
                       (wrData == DATA_W'(1) || wrData == DATA_W'(2))));

  // R5: a shutdown pulse only follows an accepted command write of 3
  a_r5_shutdown_cause: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |-> $past(wrValid && wrAddr[ADDR_W-1:2] == CMD_WORD &&
                          wrData == DATA_W'(3)));

  // R6: the two requests are never raised together
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $countones({resetReq, shutdownReq}) <= 1);

  // R11: requests are always accepted
  a_r11_always_ready: assert property (@(posedge clk) disable iff (!rstN)
    wrReady && rdReady);
endmodule

// File: rtl/sysctl_regbank_datapath.sv
module sysctl_regbank_datapath
  import sysctl_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic              rdDataValid,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] storage [NUM_WORDS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_WORDS; i++) begin
        storage[i] <= resetWord(i);
      end
    end else if (strobes.wrEn) begin
      storage[strobes.wrIdx] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdDataValid <= 1'b0;
      rdData      <= '0;
    end else begin
      rdDataValid <= strobes.rdEn;
      if (strobes.rdEn) begin
        rdData <= storage[strobes.rdIdx] | (strobes.forceBits ? STATUS_MASK : '0);
      end
    end
  end

  // R9: read data valid exactly one cycle after an accepted read
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdEn |=> rdDataValid);
  a_r9_valid_cause: assert property (@(posedge clk) disable iff (!rstN)
    rdDataValid |-> $past(strobes.rdEn));

  // R8: status reads always show bits 29:28 set
  a_r8_status_bits: assert property (@(posedge clk) disable iff (!rstN)
    (rdDataValid && $past(strobes.forceBits)) |-> (rdData[29:28] == 2'b11));
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  output logic              wrReady,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdValid,
  output logic              rdReady,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              rdDataValid,
  output logic [DATA_W-1:0] rdData,
  output logic              resetReq,
  output logic              shutdownReq
);
  ctrlStrobes_t strobes;

  sysctl_regbank_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .wrValid     (wrValid),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .rdValid     (rdValid),
    .rdAddr      (rdAddr),
    .wrReady     (wrReady),
    .rdReady     (rdReady),
    .strobes     (strobes),
    .resetReq    (resetReq),
    .shutdownReq (shutdownReq)
  );

  sysctl_regbank_datapath dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrData      (wrData),
    .rdDataValid (rdDataValid),
    .rdData      (rdData)
  );
endmodule

// File: tb/sysctl_regbank_tb_top.sv
module sysctl_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic        wrReady;
  logic [11:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        rdValid = 1'b0;
  logic        rdReady;
  logic [11:0] rdAddr = '0;
  logic        rdDataValid;
  logic [31:0] rdData;
  logic        resetReq;
  logic        shutdownReq;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  always #2 clk = ~clk;

  sysctl_regbank dut_i (
    .clk(clk), .rstN(rstN),
    .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr), .wrData(wrData),
    .rdValid(rdValid), .rdReady(rdReady), .rdAddr(rdAddr),
    .rdDataValid(rdDataValid), .rdData(rdData),
    .resetReq(resetReq), .shutdownReq(shutdownReq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [11:0] a, input logic [31:0] d,
                         input bit expRst, input bit expShut, input string tag);
    @(negedge clk);
    wrValid = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    check(resetReq == expRst, {tag, " resetReq"}, 32'(resetReq), 32'(expRst));
    check(shutdownReq == expShut, {tag, " shutdownReq"}, 32'(shutdownReq), 32'(expShut));
    @(negedge clk);
    wrValid = 1'b0;
    @(posedge clk); #1;
    check(!resetReq && !shutdownReq, {tag, " single-cycle"}, 32'({resetReq, shutdownReq}), 32'h0);
  endtask

  task automatic doRead(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rdValid = 1'b1; rdAddr = a;
    @(posedge clk); #1;
    check(rdDataValid == 1'b1, {tag, " R9 valid"}, 32'(rdDataValid), 32'h1);
    check(rdData == exp, tag, rdData, exp);
    @(negedge clk);
    rdValid = 1'b0;
    @(posedge clk); #1;
    check(rdDataValid == 1'b0, {tag, " R9 valid drop"}, 32'(rdDataValid), 32'h0);
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(!resetReq && !shutdownReq && !rdDataValid, "reset outputs",
          32'({resetReq, shutdownReq, rdDataValid}), 32'h0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testResetValues();
    doRead(12'h100, 32'h35F2_0121, "R1 id0");
    doRead(12'h104, 32'h0000_0002, "R1 id1");
    doRead(12'h108, 32'h35F3_0121, "R1 id2");
    doRead(12'h10C, 32'h35F4_0121, "R1 id3");
    doRead(12'h000, 32'h0, "R2 word0");
    doRead(12'h110, 32'h0, "R2 after ids");
    doRead(12'h7FC, 32'h0, "R2 last");
    doRead(12'hF00, 32'h0, "R2 command word");
  endtask

  task automatic testStorage();
    check(wrReady && rdReady, "R11 ready", 32'({wrReady, rdReady}), 32'h3);
    doWrite(12'h024, 32'hDEAD_BEEF, 1'b0, 1'b0, "R3 write");
    doRead(12'h024, 32'hDEAD_BEEF, "R3 readback");
    doRead(12'h027, 32'hDEAD_BEEF, "R3 low bits ignored");
    doRead(12'h824, 32'hDEAD_BEEF, "R3 alias");
    doWrite(12'h0FE, 32'h1234_5678, 1'b0, 1'b0, "R3 write low bits");
    doRead(12'h0FC, 32'h1234_5678, "R3 low bits write");
  endtask

  task automatic testCommands();
    doWrite(12'hF00, 32'h1, 1'b1, 1'b0, "R4 code1");
    doWrite(12'hF00, 32'h2, 1'b1, 1'b0, "R4 code2");
    doWrite(12'hF03, 32'h1, 1'b1, 1'b0, "R4 code1 low bits");
    doWrite(12'hF00, 32'h3, 1'b0, 1'b1, "R5 code3");
    doRead(12'hF00, 32'h3, "R7 command stored");
    doWrite(12'hF00, 32'h0, 1'b0, 1'b0, "R6 code0");
    doWrite(12'hF00, 32'h4, 1'b0, 1'b0, "R6 code4");
    doWrite(12'hF00, 32'h1_0001, 1'b0, 1'b0, "R6 high bits");
    doRead(12'hF00, 32'h1_0001, "R7 stored other");
    doWrite(12'h700, 32'h1, 1'b0, 1'b0, "R6 alias offset");
    doRead(12'hF00, 32'h1, "R3 alias command word");
    doWrite(12'h200, 32'h3, 1'b0, 1'b0, "R6 other offset");
  endtask

  task automatic testOverlay();
    doWrite(12'h100, 32'h0, 1'b0, 1'b0, "R8 clear id0");
    doRead(12'h100, 32'h3000_0000, "R8 forced 0x100");
    doWrite(12'h108, 32'hC000_0005, 1'b0, 1'b0, "R8 write 0x108");
    doRead(12'h108, 32'hF000_0005, "R8 forced 0x108");
    doWrite(12'h104, 32'h0, 1'b0, 1'b0, "R8 clear 0x104");
    doRead(12'h104, 32'h0, "R8 no force 0x104");
    doRead(12'h900, 32'h0, "R8 no force alias");
  endtask

  task automatic testNoClear();
    applyReset();
    doWrite(12'h040, 32'hA5A5_0001, 1'b0, 1'b0, "R10 seed");
    doWrite(12'hF00, 32'h2, 1'b1, 1'b0, "R10 request");
    doRead(12'h040, 32'hA5A5_0001, "R10 seed kept");
    doRead(12'h104, 32'h2, "R10 id kept");
    doRead(12'h10C, 32'h35F4_0121, "R10 id3 kept");
    applyReset();
    doRead(12'h040, 32'h0, "R10 rstN clears");
    doRead(12'hF00, 32'h0, "R10 rstN clears command");
  endtask

  initial begin
    repeat (2) @(posedge clk);
    applyReset();
    testResetValues();
    testStorage();
    testCommands();
    testOverlay();
    testNoClear();
    repeat (2) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checkCount++;
      failCount++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end
endmodule